// File: doc/BRIEF.md
# Sixteen-Bit Execute ALU

This block computes the new value of a destination register for a small 16-bit register machine. Each operation takes the old destination value, a second register value, the program counter and an 8-bit immediate, and always returns the value that replaces the destination. The operations are two-operand arithmetic and logic, a program-counter-relative add, a register copy, one-operand operations, immediate-count shifts and rotates, single-bit operations, half-register immediate loads and a signed immediate add.

The datapath itself is combinational. A single output register with a valid bit sits behind it so that results can be observed on clock edges. The register file, decoding, memory access and flags are handled elsewhere, and the block produces no carry or overflow.

Top module: `exu16`

## Requirements
- R1: Operation 1 returns dst + src and operation 2 returns dst - src, both modulo 2^16.
- R2: Operation 3 returns pc + src modulo 2^16. The old dst value has no effect on the result.
- R3: Operations 4, 5 and 6 return the bitwise AND, OR and XOR of dst and src.
- R4: Operation 7 returns src unchanged.
- R5: Operations 8, 9, 10 and 11 return dst + 1, dst - 1, 0 - dst and ~dst, all modulo 2^16.
- R6: Operations 12, 13, 14 and 15 shift dst left logically, right logically, right arithmetically (copying bit 15) or rotate it left. The count is imm[3:0] and imm[7:4] is ignored. A count of 0 returns dst unchanged.
- R7: Operations 16, 17 and 18 clear, set or toggle bit imm[3:0] of dst. Operation 19 keeps that bit of dst in its position and zeroes every other bit.
- R8: Operation 20 returns {dst[15:8], imm} and operation 21 returns {imm, dst[7:0]}.
- R9: Operation 22 returns dst plus imm sign-extended from bit 7, modulo 2^16.
- R10: Operation 0 and operations 23 to 31 return dst unchanged.
- R11: When in_valid is high at a rising edge, result and out_valid show that operation at that edge. When in_valid is low, out_valid goes low and result holds its value. While rst_n is low, result is 0 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and operation are present |
| op | input | 5 | Operation select, coded as listed in the requirements |
| dst | input | 16 | Current destination register value |
| src | input | 16 | Second register value |
| pc | input | 16 | Program counter |
| imm | input | 8 | Immediate byte |
| out_valid | output | 1 | result holds a new value |
| result | output | 16 | New destination value |

## Verification
There is one register between the operands and the port, so a wrong group select or a faulty unit shows up in result on the edge right after the operation is issued. Faults that touch only some bits need operands that exercise those bits. For that reason the vectors cover the wrap at both ends, the sign bit in arithmetic shifts, bits 0 and 15 in the bit operations, and rotates that carry bits across the word boundary. Undefined codes and a count of zero are checked against the unchanged dst, which catches a fall-through into another unit.

// File: rtl/exu16_pkg.sv
package exu16_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_SUB  = 5'd2,
    OP_ADDPC = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_MOVE = 5'd7,
    OP_INC  = 5'd8,
    OP_DEC  = 5'd9,
    OP_NEG  = 5'd10,
    OP_NOT  = 5'd11,
    OP_LSL  = 5'd12,
    OP_LSR  = 5'd13,
    OP_ASR  = 5'd14,
    OP_ROL  = 5'd15,
    OP_BCLR = 5'd16,
    OP_BSET = 5'd17,
    OP_BTOG = 5'd18,
    OP_BEXT = 5'd19,
    OP_LDLO = 5'd20,
    OP_LDHI = 5'd21,
    OP_ADDI = 5'd22
  } exu_op_e;

  localparam logic [OPW-1:0] OP_LAST = 5'd22;

  typedef enum logic [1:0] {
    GRP_PASS  = 2'd0,
    GRP_ARITH = 2'd1,
    GRP_SHBIT = 2'd2,
    GRP_HALF  = 2'd3
  } exu_grp_e;
endpackage

// File: rtl/exu16_dec.sv
module exu16_dec
  import exu16_pkg::*;
(
  input  logic [OPW-1:0] op,
  output exu_grp_e       grp,
  output logic           op_known
);
  always_comb begin
    op_known = (op <= OP_LAST);
    if (!op_known || op == OP_NOP)      grp = GRP_PASS;
    else if (op >= OP_LSL && op <= OP_BEXT) grp = GRP_SHBIT;
    else if (op == OP_LDLO || op == OP_LDHI) grp = GRP_HALF;
    else                                grp = GRP_ARITH;
  end
endmodule

// File: rtl/exu16_arith.sv
module exu16_arith
  import exu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   dst,
  input  logic [W-1:0]   src,
  input  logic [W-1:0]   pc,
  input  logic [W/2-1:0] imm,
  output logic [W-1:0]   res
);
  localparam int HALF = W / 2;

  function automatic logic [W-1:0] sext(input logic [HALF-1:0] v);
    return {{(W-HALF){v[HALF-1]}}, v};
  endfunction

  function automatic logic [W-1:0] one();
    return {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    case (op)
      OP_ADD:   res = dst + src;
      OP_SUB:   res = dst - src;
      OP_ADDPC: res = pc + src;
      OP_AND:   res = dst & src;
      OP_OR:    res = dst | src;
      OP_XOR:   res = dst ^ src;
      OP_MOVE:  res = src;
      OP_INC:   res = dst + one();
      OP_DEC:   res = dst - one();
      OP_NEG:   res = {W{1'b0}} - dst;
      OP_NOT:   res = ~dst;
      OP_ADDI:  res = dst + sext(imm);
      default:  res = dst;
    endcase
  end
endmodule

// File: rtl/exu16_shbit.sv
module exu16_shbit
  import exu16_pkg::*;
#(
  parameter int W = 16,
  localparam int SHW = $clog2(W)
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   dst,
  input  logic [SHW-1:0] cnt,
  output logic [W-1:0]   res
);
  function automatic logic [W-1:0] rotl(input logic [W-1:0] a, input logic [SHW-1:0] n);
    logic [2*W-1:0] t;
    t = {a, a} << n;
    return t[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] sra(input logic [W-1:0] a, input logic [SHW-1:0] n);
    return W'($signed(a) >>> n);
  endfunction

  function automatic logic [W-1:0] bitmask(input logic [SHW-1:0] n);
    return {{(W-1){1'b0}}, 1'b1} << n;
  endfunction

  logic [W-1:0] mask;
  assign mask = bitmask(cnt);

  always_comb begin
    case (op)
      OP_LSL:  res = dst << cnt;
      OP_LSR:  res = dst >> cnt;
      OP_ASR:  res = sra(dst, cnt);
      OP_ROL:  res = rotl(dst, cnt);
      OP_BCLR: res = dst & ~mask;
      OP_BSET: res = dst | mask;
      OP_BTOG: res = dst ^ mask;
      OP_BEXT: res = dst & mask;
      default: res = dst;
    endcase
  end
endmodule

// File: rtl/exu16_half.sv
module exu16_half
  import exu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   dst,
  input  logic [W/2-1:0] imm,
  output logic [W-1:0]   res
);
  localparam int HALF = W / 2;

  always_comb begin
    case (op)
      OP_LDLO: res = {dst[W-1:HALF], imm};
      OP_LDHI: res = {imm, dst[HALF-1:0]};
      default: res = dst;
    endcase
  end
endmodule

// File: rtl/exu16.sv
module exu16
  import exu16_pkg::*;
#(
  parameter int W = 16,
  localparam int HALF = W / 2,
  localparam int SHW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op,
  input  logic [W-1:0]    dst,
  input  logic [W-1:0]    src,
  input  logic [W-1:0]    pc,
  input  logic [HALF-1:0] imm,
  output logic            out_valid,
  output logic [W-1:0]    result
);
  exu_grp_e     grp;
  logic         op_known;
  logic [W-1:0] arith_res;
  logic [W-1:0] shbit_res;
  logic [W-1:0] half_res;
  logic [W-1:0] next_res;

  exu16_dec u_dec (
    .op       (op),
    .grp      (grp),
    .op_known (op_known)
  );

  exu16_arith #(.W(W)) u_arith (
    .op  (op),
    .dst (dst),
    .src (src),
    .pc  (pc),
    .imm (imm),
    .res (arith_res)
  );

  exu16_shbit #(.W(W)) u_shbit (
    .op  (op),
    .dst (dst),
    .cnt (imm[SHW-1:0]),
    .res (shbit_res)
  );

  exu16_half #(.W(W)) u_half (
    .op  (op),
    .dst (dst),
    .imm (imm),
    .res (half_res)
  );

  always_comb begin
    case (grp)
      GRP_ARITH: next_res = arith_res;
      GRP_SHBIT: next_res = shbit_res;
      GRP_HALF:  next_res = half_res;
      default:   next_res = dst;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/exu16_chk.sv
module exu16_chk
  import exu16_pkg::*;
#(
  parameter int W = 16,
  localparam int HALF = W / 2,
  localparam int SHW = $clog2(W)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [OPW-1:0]  op,
  input logic [W-1:0]    dst,
  input logic [W-1:0]    src,
  input logic [W-1:0]    pc,
  input logic [HALF-1:0] imm,
  input logic            out_valid,
  input logic [W-1:0]    result,
  input logic            op_known
);
  logic [W-1:0] one_hot;
  assign one_hot = {{(W-1){1'b0}}, 1'b1} << imm[SHW-1:0];

  assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_pc_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ADDPC) |=> result == $past(pc + src));
  assert_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_MOVE) |=> result == $past(src));
  assert_undef_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_known) |=> result == $past(dst));
  assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= OP_LSL && op <= OP_ROL && imm[SHW-1:0] == '0)
      |=> result == $past(dst));
  assert_bit_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_BSET) |=> result == ($past(dst) | $past(one_hot)));
  assert_bit_extract_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_BEXT) |=> $countones(result) <= 1);
  assert_low_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_LDLO) |=> result == {$past(dst[W-1:HALF]), $past(imm)});
endmodule

bind exu16 exu16_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .dst       (dst),
  .src       (src),
  .pc        (pc),
  .imm       (imm),
  .out_valid (out_valid),
  .result    (result),
  .op_known  (op_known)
);

// File: tb/exu16_bench.sv
module exu16_bench;
  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] dst;
    logic [15:0] src;
    logic [15:0] pc;
    logic [7:0]  imm;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [0:NV-1] = '{
    '{5'd1,  16'h1234, 16'h1111, 16'h0000, 8'h00, 16'h2345, 4'd1},  // R1 add
    '{5'd1,  16'hFFFF, 16'h0002, 16'h0000, 8'h00, 16'h0001, 4'd1},  // R1 wrap up
    '{5'd2,  16'h0005, 16'h0007, 16'h0000, 8'h00, 16'hFFFE, 4'd1},  // R1 wrap down
    '{5'd3,  16'hDEAD, 16'h0020, 16'h0100, 8'h00, 16'h0120, 4'd2},  // R2
    '{5'd3,  16'h0000, 16'h0020, 16'hFFF0, 8'h00, 16'h0010, 4'd2},  // R2 wrap
    '{5'd4,  16'hF0F0, 16'h3C3C, 16'h0000, 8'h00, 16'h3030, 4'd3},  // R3 and
    '{5'd5,  16'hF0F0, 16'h3C3C, 16'h0000, 8'h00, 16'hFCFC, 4'd3},  // R3 or
    '{5'd6,  16'hF0F0, 16'h3C3C, 16'h0000, 8'h00, 16'hCCCC, 4'd3},  // R3 xor
    '{5'd7,  16'h1111, 16'hABCD, 16'h5555, 8'h12, 16'hABCD, 4'd4},  // R4
    '{5'd8,  16'hFFFF, 16'h0000, 16'h0000, 8'h00, 16'h0000, 4'd5},  // R5 inc
    '{5'd9,  16'h0000, 16'h0000, 16'h0000, 8'h00, 16'hFFFF, 4'd5},  // R5 dec
    '{5'd10, 16'h0001, 16'h0000, 16'h0000, 8'h00, 16'hFFFF, 4'd5},  // R5 neg
    '{5'd10, 16'h8000, 16'h0000, 16'h0000, 8'h00, 16'h8000, 4'd5},  // R5 neg min
    '{5'd11, 16'h5A5A, 16'h0000, 16'h0000, 8'h00, 16'hA5A5, 4'd5},  // R5 not
    '{5'd12, 16'h8001, 16'h0000, 16'h0000, 8'h01, 16'h0002, 4'd6},  // R6 lsl
    '{5'd13, 16'h8001, 16'h0000, 16'h0000, 8'h0F, 16'h0001, 4'd6},  // R6 lsr
    '{5'd14, 16'h8000, 16'h0000, 16'h0000, 8'h04, 16'hF800, 4'd6},  // R6 asr neg
    '{5'd14, 16'h7FF0, 16'h0000, 16'h0000, 8'h04, 16'h07FF, 4'd6},  // R6 asr pos
    '{5'd15, 16'h8001, 16'h0000, 16'h0000, 8'h04, 16'h0018, 4'd6},  // R6 rol
    '{5'd15, 16'h1234, 16'h0000, 16'h0000, 8'hF4, 16'h2341, 4'd6},  // R6 upper imm ignored
    '{5'd12, 16'hABCD, 16'h0000, 16'h0000, 8'h00, 16'hABCD, 4'd6},  // R6 zero count
    '{5'd16, 16'hFFFF, 16'h0000, 16'h0000, 8'h0F, 16'h7FFF, 4'd7},  // R7 clr
    '{5'd17, 16'h0000, 16'h0000, 16'h0000, 8'h03, 16'h0008, 4'd7},  // R7 set
    '{5'd18, 16'h00FF, 16'h0000, 16'h0000, 8'h00, 16'h00FE, 4'd7},  // R7 tog
    '{5'd19, 16'hFFFF, 16'h0000, 16'h0000, 8'h09, 16'h0200, 4'd7},  // R7 ext one
    '{5'd19, 16'hFDFF, 16'h0000, 16'h0000, 8'h09, 16'h0000, 4'd7},  // R7 ext zero
    '{5'd20, 16'h1234, 16'h0000, 16'h0000, 8'hAB, 16'h12AB, 4'd8},  // R8 low
    '{5'd21, 16'h1234, 16'h0000, 16'h0000, 8'hAB, 16'hAB34, 4'd8},  // R8 high
    '{5'd22, 16'h0010, 16'h0000, 16'h0000, 8'hFF, 16'h000F, 4'd9},  // R9 minus one
    '{5'd22, 16'hFFF0, 16'h0000, 16'h0000, 8'h7F, 16'h006F, 4'd9},  // R9 wrap
    '{5'd22, 16'h0000, 16'h0000, 16'h0000, 8'h80, 16'hFF80, 4'd9},  // R9 most negative
    '{5'd0,  16'h4321, 16'hFFFF, 16'h1111, 8'hFF, 16'h4321, 4'd10}, // R10 code 0
    '{5'd31, 16'h9999, 16'h0001, 16'h0000, 8'h01, 16'h9999, 4'd10}, // R10 code 31
    '{5'd23, 16'h0F0F, 16'h1234, 16'h0000, 8'h05, 16'h0F0F, 4'd10}  // R10 code 23
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [15:0] dst = '0;
  logic [15:0] src = '0;
  logic [15:0] pc = '0;
  logic [7:0]  imm = '0;
  logic        out_valid;
  logic [15:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exu16 u_exu16 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .dst(dst),
    .src(src), .pc(pc), .imm(imm), .out_valid(out_valid), .result(result)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset valid", {15'd0, out_valid}, 16'h0000);
    check("R11 reset result", result, 16'h0000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      op = VECS[i].op; dst = VECS[i].dst; src = VECS[i].src;
      pc = VECS[i].pc; imm = VECS[i].imm;
      @(negedge clk);
      checks++;
      if (result !== VECS[i].exp || out_valid !== 1'b1) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual %h valid %b expected %h valid 1",
                 VECS[i].req, i, result, out_valid, VECS[i].exp);
      end
    end
    // R11 idle: valid drops, result holds last value 0F0F
    in_valid = 1'b0; op = 5'd1; dst = 16'h0001; src = 16'h0001;
    @(negedge clk);
    check("R11 idle valid", {15'd0, out_valid}, 16'h0000);
    check("R11 idle hold", result, 16'h0F0F);
    @(negedge clk);
    check("R11 idle hold 2", result, 16'h0F0F);
    // R2 old dst has no effect: same pc/src, different dst
    in_valid = 1'b1; op = 5'd3; pc = 16'h2000; src = 16'h0003; dst = 16'h0000;
    @(negedge clk);
    check("R2 dst zero", result, 16'h2003);
    dst = 16'hFFFF;
    @(negedge clk);
    check("R2 dst ones", result, 16'h2003);
    // R6 rotate by 15 equals rotate right by one
    op = 5'd15; dst = 16'h0001; imm = 8'h0F;
    @(negedge clk);
    check("R6 rol 15", result, 16'h8000);
    // R11 asynchronous reset clears mid-run
    #3 rst_n = 1'b0;
    #2;
    check("R11 async reset result", result, 16'h0000);
    check("R11 async reset valid", {15'd0, out_valid}, 16'h0000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule